// File: doc/BRIEF.md
# Costas Carrier Loop Filter and Phase Accumulator

This block closes the carrier-tracking loop of a binary phase-shift keying demodulator built around a Costas loop. Once per input sample, at 8000 samples per second, it takes the low-pass-filtered in-phase (data) arm and quadrature (error) arm values. Both are signed 16-bit. From them it forms a decision-directed phase error. The in-phase arm is reduced to its sign, and that sign sets the polarity of the quadrature arm.

The error drives a leaky integrator that forgets one sixteenth of its value per sample. A small direct path adds the scaled present error on top of the integrator output. The resulting correction, together with a fixed nominal frequency word, advances a 14-bit carrier phase accumulator. The new phase is presented one clock after each accepted sample, and a downstream tone generator turns it into the mixing sinusoids.

Top module: `costas_loop_nco`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `phase` reads 0 and `phase_valid` reads 0. The integrator state is also cleared, so a first sample with zero error advances the phase by exactly the frequency word.
- R2: `phase_valid` is 1 in the clock cycle after a cycle with `in_valid` high, and 0 after a cycle with `in_valid` low. While `in_valid` is low, `phase` and the integrator hold their values.
- R3: The phase error e equals `q_arm` when `i_arm` is zero or positive (sign bit 0). It equals the negation of `q_arm` when `i_arm` is negative (sign bit 1). The error is kept 17 bits wide, so negating -32768 gives +32768.
- R4: Each accepted sample updates the integrator state s to floor((s*61440 + e*2^(16-K)) / 2^16), with K = 6 by default. This is a 15/16 decay plus e/64, taken as the high word of the accumulation.
- R5: The correction is c = s_new + floor(e / 2^K), where s_new is the freshly updated integrator value. The new phase is (phase + c + F) mod 2^14, with F the frequency word.
- R6: The phase is a 14-bit accumulator that wraps modulo 16384. Both a positive overflow and a negative correction wrap into 0..16383.
- R7: The integrator state saturates at +32767 and -32768 instead of wrapping. This is reachable when K = 0.
- R8: The frequency word loads 3072 on reset, which is 1500 Hz at 8000 samples per second. It stays within the bounds 2400..4095 and is held at that value. With zero error, each sample advances the phase by 3072.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new pair of arm samples is present this cycle |
| i_arm | input | 16 | Filtered in-phase (data) arm sample, signed |
| q_arm | input | 16 | Filtered quadrature (error) arm sample, signed |
| phase_valid | output | 1 | `phase` has just been updated from a sample |
| phase | output | 14 | Carrier phase for the tone generator, 16384 = one turn |

## Verification
The bench goes after four kinds of error.
- **Sign decision.** It checks the sign decision with `i_arm` negative, positive and exactly zero. A detector that treated zero as negative, or that used the in-phase magnitude, would step the phase the wrong way.
- **Filter arithmetic.** It runs a long pseudo-random sequence against a bench model of the decay, the proportional path and the floor-rounded high-word shifts. An off-by-one shift, rounding toward zero, or using the old integrator value in the correction shows up as a phase mismatch within a few samples.
- **Accumulator wrap and idle hold.** It drives the accumulator across 16384 and through negative corrections to catch a missing wrap. Idle cycles expose a phase that drifts without a sample.
- **Saturation and extreme inputs.** A second instance with no error scaling pushes the integrator into both rails and feeds q = -32768 with a negative data arm. A wrapping integrator or a 16-bit negation would then turn a large correction into the opposite sign.

// File: rtl/costas_loop_nco.sv
module costas_loop_nco #(
  parameter int DW       = 16,
  parameter int PW       = 14,
  parameter int FW       = 13,
  parameter int FREQ_NOM = 3072,
  parameter int FREQ_LO  = 2400,
  parameter int FREQ_HI  = 4095,
  parameter int ERR_SH   = 6,
  parameter int LEAK_SH  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] i_arm,
  input  logic signed [DW-1:0] q_arm,
  output logic                 phase_valid,
  output logic [PW-1:0]        phase
);

  localparam int EW = DW + 1;
  localparam int HW = 16;
  localparam int AW = DW + HW + 2;
  localparam logic signed [AW-1:0] IMAX = AW'((1 <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] IMIN = -AW'(1 <<< (DW-1));
  localparam int FREQ_INIT = (FREQ_NOM > FREQ_HI) ? FREQ_HI :
                             (FREQ_NOM < FREQ_LO) ? FREQ_LO : FREQ_NOM;

  logic signed [DW-1:0] integ, integ_nx;
  logic signed [EW-1:0] err;
  logic signed [AW-1:0] acc_hi;
  logic [FW-1:0]        freq;
  logic [PW-1:0]        corr_lo, phase_nx;

  // decision-directed error: data arm sign flips the quadrature arm
  assign err = i_arm[DW-1] ? -EW'(q_arm) : EW'(q_arm);

  // leaky integrator, high word of the accumulation
  assign acc_hi = ((AW'(integ) <<< HW) - (AW'(integ) <<< (HW - LEAK_SH))
                   + (AW'(err) <<< (HW - ERR_SH))) >>> HW;

  assign integ_nx = (acc_hi > IMAX) ? IMAX[DW-1:0] :
                    (acc_hi < IMIN) ? IMIN[DW-1:0] : acc_hi[DW-1:0];

  assign corr_lo  = PW'(integ_nx) + PW'(err >>> ERR_SH);
  assign phase_nx = phase + corr_lo + PW'(freq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ       <= '0;
      phase       <= '0;
      phase_valid <= 1'b0;
      freq        <= FW'(FREQ_INIT);
    end else begin
      phase_valid <= in_valid;
      if (in_valid) begin
        integ <= integ_nx;
        phase <= phase_nx;
      end
    end
  end

  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    return v[DW-1] ? (DW+1)'(-(DW+1)'(v)) : (DW+1)'(v);
  endfunction

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> phase_valid);

  // R2
  valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !phase_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phase) && $stable(integ)));

  // R4
  leak_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && q_arm == '0) |=> (mag(integ) <= mag($past(integ))));

  // R8
  freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq >= FW'(FREQ_LO)) && (freq <= FW'(FREQ_HI)));

endmodule

// File: tb/costas_loop_nco_bench.sv
module costas_loop_nco_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] i_arm = '0, q_arm = '0;
  logic        pv0, pv1;
  logic [13:0] ph0, ph1;
  int checks = 0, fails = 0;
  longint m_ph[2], m_in[2];
  int sh[2] = '{6, 0};

  always #4 clk = ~clk;

  costas_loop_nco u_costas_loop_nco (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .i_arm(i_arm), .q_arm(q_arm), .phase_valid(pv0), .phase(ph0));

  costas_loop_nco #(.ERR_SH(0)) u_costas_loop_nco_sat (.clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .i_arm(i_arm), .q_arm(q_arm), .phase_valid(pv1), .phase(ph1));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(int k, longint i, longint q);
    longint e, acc, nx;
    e   = (i < 0) ? -q : q;
    acc = m_in[k] * 61440 + e * (longint'(1) <<< (16 - sh[k]));
    nx  = acc >>> 16;
    if (nx > 32767) nx = 32767;
    if (nx < -32768) nx = -32768;
    m_in[k] = nx;
    m_ph[k] = (m_ph[k] + nx + (e >>> sh[k]) + 3072) & 16383;
  endtask

  task automatic step(string req, int i, int q);
    @(negedge clk);
    in_valid = 1'b1;
    i_arm = 16'(i);
    q_arm = 16'(q);
    model(0, i, q);
    model(1, i, q);
    @(posedge clk);
    #1;
    chk({req, " phase"}, ph0, m_ph[0]);
    chk("R2 valid", pv0, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 phase in reset", ph0, 0);
    chk("R1 valid in reset", pv0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_ph = '{0, 0};
    m_in = '{0, 0};
    @(posedge clk);
    #1;
    chk("R1 phase after reset", ph0, 0);
    chk("R1 valid after reset", pv0, 0);
  endtask

  task automatic t_nominal();
    step("R1 R8 first zero-error step", 0, 0);
    chk("R8 step is 3072", ph0, 3072);
    for (int n = 0; n < 5; n++) step("R8 zero-error step", 0, 0);
    chk("R6 wrap past 16384", ph0, 2048);
  endtask

  task automatic t_idle();
    logic [13:0] held;
    held = ph0;
    @(negedge clk);
    in_valid = 1'b0;
    i_arm = 16'sd9000;
    q_arm = 16'sd9000;
    for (int n = 0; n < 4; n++) begin
      @(posedge clk);
      #1;
      chk("R2 valid low when idle", pv0, 0);
      chk("R2 phase held when idle", ph0, held);
    end
    step("R2 integrator held when idle", 0, 0);
  endtask

  task automatic t_sign();
    step("R3 positive data arm", 5000, 6400);
    step("R3 negative data arm", -5000, 6400);
    step("R3 zero data arm", 0, 6400);
    step("R3 negative arm negative q", -1, -12800);
    step("R6 negative correction wrap", 100, -32768);
  endtask

  task automatic t_filter();
    int unsigned s = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      s = s * 1103515245 + 12345;
      step("R4 R5 random sample", int'(signed'(s[30:15])), int'(signed'(s[22:7])));
    end
    for (int n = 0; n < 20; n++) step("R4 decay with zero error", 3, 0);
  endtask

  task automatic t_sat();
    for (int n = 0; n < 3; n++) begin
      step("R7 drive to upper rail", 1000, 32767);
      chk("R7 sat instance phase", ph1, m_ph[1]);
    end
    chk("R7 model at upper rail", m_in[1], 32767);
    for (int n = 0; n < 3; n++) begin
      step("R7 drive to lower rail", 1000, -32768);
      chk("R7 sat instance phase", ph1, m_ph[1]);
    end
    chk("R7 model at lower rail", m_in[1], -32768);
    step("R3 R7 negate -32768", -1, -32768);
    chk("R7 sat instance after negate", ph1, m_ph[1]);
    for (int n = 0; n < 3; n++) begin
      step("R7 release from rail", 0, 0);
      chk("R7 sat instance decay", ph1, m_ph[1]);
    end
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_idle();
    t_sign();
    t_filter();
    t_sat();
    @(negedge clk);
    in_valid = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule